// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a procedure return will jump. At fetch, each call instruction pushes the address of the instruction that follows it onto a small hardware stack. Each return instruction pops the top entry, and that entry is offered as the predicted next fetch address in the same cycle as the return strobe. Fetch logic raises `call_i` or `ret_i` together with the PC of the instruction being fetched. It uses `pred_addr_o` as the next PC whenever `pred_valid_o` is high.

The stack is circular and has `DEPTH` entries, where `DEPTH` is between 8 and 16. A push onto a full stack overwrites the oldest entry and does not stall. A return on an empty stack produces no prediction and changes no state. If a call and a return arrive in the same cycle, the block first pops, giving the current top as the prediction, and then pushes the new return address. On a non-empty stack this replaces the top entry.

Top module: `ras_predictor`

## Requirements
- R1: A call at PC `p` pushes `p + 4`. The return that follows predicts `p + 4`. Instructions are 4 bytes and addresses are `ADDR_W` bits wide, with wrap-around addition.
- R2: A return on a non-empty stack drives `pred_valid_o = 1` and `pred_addr_o` equal to the top entry in the same cycle, combinationally. The entry is removed at the next rising clock edge.
- R3: Nested calls unwind in last-in first-out order. After calls at 0x104 and then 0x124, successive returns predict 0x128 and then 0x108.
- R4: A return on an empty stack gives `pred_valid_o = 0` and `pred_addr_o = 0`, and leaves the stack unchanged. A later call and return behave as if the empty return never happened.
- R5: Outside a return strobe, `pred_valid_o` is 0 and `pred_addr_o` is 0.
- R6: After `DEPTH + k` calls without returns, the most recent `DEPTH` return addresses are retained and the oldest `k` are overwritten. The next `DEPTH` returns predict the retained addresses, newest first. The return after those reports no prediction.
- R7: A call and a return in the same cycle on a non-empty stack predict the current top. The top is then replaced with the call's PC + 4, and the number of entries stays the same.
- R8: A call and a return in the same cycle on an empty stack give no prediction, and the call's PC + 4 is pushed as a single entry.
- R9: While `rst_ni` is low, and after it is released, the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | A call instruction is being fetched |
| ret_i | input | 1 | A return instruction is being fetched |
| pc_i | input | ADDR_W | PC of the instruction being fetched |
| pred_addr_o | output | ADDR_W | Predicted return target; 0 when not valid |
| pred_valid_o | output | 1 | Prediction available this cycle |

## Verification
The push of a call and the pop of a return can fall in the same cycle. The bench provokes this by raising `call_i` and `ret_i` together in two states. On a stack holding two entries, it expects the old top as the prediction. The following returns must then yield the new PC + 4 and then the untouched lower entry. On an empty stack, it expects no prediction, and the next returns must yield exactly one entry.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    RAS_IDLE,
    RAS_PUSH,
    RAS_POP,
    RAS_SWAP
  } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  output logic [IDX_W-1:0] top_idx_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             empty_o
);

  logic [IDX_W-1:0] tp_q, tp_up, tp_dn;
  logic [CNT_W-1:0] cnt_q;

  assign tp_up = (tp_q == IDX_W'(DEPTH - 1)) ? '0 : tp_q + 1'b1;
  assign tp_dn = (tp_q == '0) ? IDX_W'(DEPTH - 1) : tp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (op_i)
        RAS_PUSH: begin
          tp_q <= tp_up;
          // full stack: oldest slot is overwritten, count saturates
          if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end
        RAS_POP: begin
          tp_q  <= tp_dn;
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top_idx_o = tp_q;
  assign wr_idx_o  = (op_i == RAS_PUSH) ? tp_up : tp_q;
  assign empty_o   = (cnt_q == '0);

  a_r4_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_POP || op_i == RAS_SWAP) |-> cnt_q != '0);

  a_r6_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r6_full_push_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_PUSH && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));

  a_r3_pop_retreats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == RAS_POP |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r7_swap_holds_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == RAS_SWAP |=> ($stable(cnt_q) && $stable(tp_q)));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [ADDR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pred_addr_o,
  output logic              pred_valid_o
);

  localparam int IDX_W = $clog2(DEPTH);

  ras_op_e           op;
  logic              empty, pop_ok;
  logic [IDX_W-1:0]  top_idx, wr_idx;
  logic [ADDR_W-1:0] top_data, ret_addr;

  assign pop_ok   = ret_i && !empty;
  assign ret_addr = pc_i + ADDR_W'(INSN_BYTES);

  // call+ret: pop then push; on empty the pop is void and only the push remains
  always_comb begin
    if (call_i && pop_ok) op = RAS_SWAP;
    else if (call_i)      op = RAS_PUSH;
    else if (pop_ok)      op = RAS_POP;
    else                  op = RAS_IDLE;
  end

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .top_idx_o(top_idx),
    .wr_idx_o (wr_idx),
    .empty_o  (empty)
  );

  ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (op == RAS_PUSH || op == RAS_SWAP),
    .wr_idx_i (wr_idx),
    .wr_data_i(ret_addr),
    .rd_idx_i (top_idx),
    .rd_data_o(top_data)
  );

  assign pred_valid_o = pop_ok;
  assign pred_addr_o  = pop_ok ? top_data : '0;

  a_r1_call_sets_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> top_data == $past(ret_addr));

  a_r8_empty_swap_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && empty) |=> !empty);

  a_r4_empty_ret_keeps_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && empty) |=> empty);

endmodule

// File: tb/tb_ras_predictor.sv
`timescale 1ns/1ps
module tb_ras_predictor;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              call_i = 1'b0;
  logic              ret_i = 1'b0;
  logic [ADDR_W-1:0] pc_i = '0;
  logic [ADDR_W-1:0] pred_addr_o;
  logic              pred_valid_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INSN_BYTES(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .pc_i(pc_i), .pred_addr_o(pred_addr_o), .pred_valid_o(pred_valid_o)
  );

  // drive one fetch slot at the falling edge, check combinational outputs 1 ns later
  task automatic slot(input logic c, input logic r, input logic [ADDR_W-1:0] pc,
                      input logic exp_v, input logic [ADDR_W-1:0] exp_a, input string req);
    @(negedge clk);
    call_i = c; ret_i = r; pc_i = pc;
    #1;
    checks++;
    if (pred_valid_o !== exp_v || pred_addr_o !== exp_a) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, pred_valid_o, pred_addr_o, exp_v, exp_a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    call_i = 0; ret_i = 0; pc_i = '0;
    rst_ni = 0;
    #1;
    checks++;
    if (pred_valid_o !== 1'b0 || pred_addr_o !== '0) begin
      errors++;
      $display("FAIL R9: in reset valid=%0b addr=%h expected valid=0 addr=0",
               pred_valid_o, pred_addr_o);
    end
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic t_reset();
    do_reset();
    slot(0, 1, 32'h0, 0, 32'h0, "R9 empty after reset");
    slot(0, 0, 32'h0, 0, 32'h0, "R5 idle");
  endtask

  task automatic t_single();
    do_reset();
    slot(1, 0, 32'h104, 0, 32'h0, "R5 call gives no prediction");
    slot(0, 0, 32'h0,   0, 32'h0, "R5 idle after call");
    slot(0, 1, 32'h10c, 1, 32'h108, "R1 R2 return predicts pc+4");
    slot(0, 1, 32'h10c, 0, 32'h0, "R2 entry removed after pop");
  endtask

  task automatic t_nested();
    do_reset();
    slot(1, 0, 32'h104, 0, 32'h0, "R3 call outer");
    slot(1, 0, 32'h124, 0, 32'h0, "R3 call inner");
    slot(0, 1, 32'h12c, 1, 32'h128, "R3 inner return first");
    slot(0, 1, 32'h10c, 1, 32'h108, "R3 outer return second");
    slot(0, 1, 32'h10c, 0, 32'h0,   "R3 unwound to empty");
  endtask

  task automatic t_empty_pop();
    do_reset();
    for (int i = 0; i < 3; i++) slot(0, 1, 32'h50, 0, 32'h0, "R4 empty return");
    slot(1, 0, 32'h200, 0, 32'h0, "R4 call after empty returns");
    slot(0, 1, 32'h208, 1, 32'h204, "R4 single entry intact");
    slot(0, 1, 32'h208, 0, 32'h0,   "R4 no phantom entry");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH + 3; i++)
      slot(1, 0, 32'h1000 + 32'h40 * i, 0, 32'h0, "R6 fill");
    for (int i = DEPTH + 2; i >= 3; i--)
      slot(0, 1, 32'h0, 1, 32'h1004 + 32'h40 * i, "R6 retained newest first");
    slot(0, 1, 32'h0, 0, 32'h0, "R6 overwritten entries give no prediction");
  endtask

  task automatic t_swap();
    do_reset();
    slot(1, 0, 32'h104, 0, 32'h0, "R7 call outer");
    slot(1, 0, 32'h124, 0, 32'h0, "R7 call inner");
    slot(1, 1, 32'h300, 1, 32'h128, "R7 call+ret predicts old top");
    slot(0, 1, 32'h0, 1, 32'h304, "R7 top replaced");
    slot(0, 1, 32'h0, 1, 32'h108, "R7 lower entry untouched");
    slot(0, 1, 32'h0, 0, 32'h0,   "R7 depth unchanged");
  endtask

  task automatic t_swap_empty();
    do_reset();
    slot(1, 1, 32'h400, 0, 32'h0,   "R8 call+ret on empty");
    slot(0, 1, 32'h0,   1, 32'h404, "R8 pushed entry");
    slot(0, 1, 32'h0,   0, 32'h0,   "R8 only one entry");
  endtask

  task automatic t_wrap_add();
    do_reset();
    slot(1, 0, 32'hffff_fffc, 0, 32'h0, "R1 call at top of space");
    slot(0, 1, 32'h0, 1, 32'h0, "R1 pc+4 wraps");
  endtask

  initial begin
    t_reset();
    t_single();
    t_nested();
    t_empty_pop();
    t_overflow();
    t_swap();
    t_swap_empty();
    t_wrap_add();
    @(negedge clk);
    call_i = 0; ret_i = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule